// File: doc/BRIEF.md
# Indexed predicate select unit

This execution unit performs a vector predicate select steered by one element of a second predicate. It receives a 5-bit encoded field, a 32-bit unsigned index value and two predicate operands. The low four bits of the encoded field give the element size. The bits above the size marker give a small immediate. The unit adds the immediate to the index and wraps the sum to the number of elements of that size in the vector. It then tests the predicate bit of that element in the second operand. If the bit is set, the result is the first operand. If it is clear, the result is all zeros.

The vector length `VL_BITS` is a power-of-two parameter from 128 to 2048. A predicate holds one bit per byte of vector, so it is `VL_BITS/8` bits wide. The index comes from one of four general registers, numbered 12 to 15, and the unit drives that register number combinationally so the register file can be read. Operands are captured on `in_valid`, and the result appears one cycle later with `out_valid`. An encoding with no size marker raises `out_undef`, and no write is requested for it. No condition flags are produced.

Top module: `pred_pick_unit`

## Requirements
- R1: The low four bits of `enc_fld` select the element size. Pattern xxx1 selects bytes, xx10 selects halfwords (16 bits), x100 selects words (32 bits), 1000 selects doublewords (64 bits), and 0000 is reserved.
- R2: The immediate is the part of `enc_fld` above the size marker: bits [4:1] for bytes, [4:2] for halfwords, [4:3] for words, and bit [4] alone for doublewords.
- R3: The element number is (`idx_val` taken as an unsigned 32-bit value + immediate) modulo (VL_BITS / element size in bits). A 32-bit index near its maximum wraps correctly.
- R4: Element e is active when `src_gate` bit e × (element bytes) is set. Gate bits at other positions have no effect.
- R5: For a legal encoding, `out_pred` equals the captured `src_keep` when the selected element is active, and is all zeros otherwise.
- R6: For a reserved encoding, `out_undef` is 1, `out_pred` is zero and `out_wr` is 0. For a legal encoding, `out_undef` is 0.
- R7: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. `out_pred` and `out_undef` keep their values while `in_valid` is low.
- R8: `ridx_num` equals {3'b011, `ridx_sel`} at all times, which gives register numbers 12 to 15.
- R9: While `rst_n` is low, `out_valid`, `out_wr`, `out_undef` and `out_pred` are all zero.
- R10: `out_wr` equals `out_valid` AND NOT `out_undef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Capture strobe for the operands |
| enc_fld | input | 5 | Size marker in the low four bits, with the immediate above it |
| ridx_sel | input | 2 | Selects which of the index registers 12 to 15 supplies the index |
| idx_val | input | 32 | Unsigned index value read from the selected register |
| src_keep | input | VL_BITS/8 | First predicate operand, passed to the result when selected |
| src_gate | input | VL_BITS/8 | Second predicate operand, whose element is tested |
| ridx_num | output | 5 | Register number used for the index read |
| out_valid | output | 1 | Result valid |
| out_wr | output | 1 | Result write request |
| out_undef | output | 1 | Reserved-encoding flag |
| out_pred | output | VL_BITS/8 | Result predicate |

## Verification
The assertions check the timing and the invariants on every cycle:
- `out_valid` follows `in_valid` one cycle later.
- The result and the undefined flag hold while no capture occurs.
- A reserved result is zero and raises no write.
- A valid result is either zero or the captured first operand.
- The decoded immediate stays inside the element count for its size.

The assertions cannot show that the chosen element is the right one. The bench scenarios show this: each element size, indexes that wrap past the element count and past the 32-bit limit, gate bits placed between element positions, an all-false second operand, and the reserved encoding.

// File: rtl/pps_pkg.sv
package pps_pkg;
  // element size code; the value is also log2(element bytes)
  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_S = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  localparam int unsigned IDX_W = 32;
  localparam int unsigned ENC_W = 5;
  localparam int unsigned IMM_W = 4;
endpackage

// File: rtl/pps_size_dec.sv
module pps_size_dec
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ENC_W-1:0] enc,
  output esz_e             esz,
  output logic [IMM_W-1:0] imm,
  output logic             rsv
);

  // lowest set bit of enc[3:0] marks the size; bits above it form the immediate
  always_comb begin
    esz = ESZ_B;
    imm = '0;
    rsv = 1'b0;
    casez (enc[3:0])
      4'b???1: begin esz = ESZ_B; imm = enc[4:1];               end
      4'b??10: begin esz = ESZ_H; imm = {1'b0, enc[4:2]};       end
      4'b?100: begin esz = ESZ_S; imm = {2'b00, enc[4:3]};      end
      4'b1000: begin esz = ESZ_D; imm = {3'b000, enc[4]};       end
      default: begin rsv = 1'b1;                                 end
    endcase
  end

  // R2: immediate never reaches the element count of a 128-bit slice
  a_r2_imm_range: assert property (@(posedge clk) disable iff (!rst_n)
    !rsv |-> (({1'b0, imm} >> (3'd4 - {1'b0, esz})) == 5'd0));

endmodule

// File: rtl/pps_elem_pick.sv
module pps_elem_pick
  import pps_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]       sh,
  input  logic [PW-1:0]    gate,
  output logic             hit
);

  localparam int unsigned LB = $clog2(PW);

  logic [IDX_W:0] sum;
  logic [LB-1:0]  low;
  logic [LB-1:0]  pos;
  logic           unused_hi;

  // the element count is a power of two dividing 2^32, so wrapping is a mask;
  // scaling by element bytes before the mask drops exactly the wrapped bits
  assign sum       = {1'b0, idx} + (IDX_W + 1)'(imm);
  assign low       = sum[LB-1:0];
  assign pos       = low << sh;
  assign hit       = gate[pos];
  assign unused_hi = ^sum[IDX_W:LB];

endmodule

// File: rtl/pred_pick_unit.sv
module pred_pick_unit
  import pps_pkg::*;
#(
  parameter int unsigned VL_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [ENC_W-1:0]     enc_fld,
  input  logic [1:0]           ridx_sel,
  input  logic [IDX_W-1:0]     idx_val,
  input  logic [VL_BITS/8-1:0] src_keep,
  input  logic [VL_BITS/8-1:0] src_gate,
  output logic [4:0]           ridx_num,
  output logic                 out_valid,
  output logic                 out_wr,
  output logic                 out_undef,
  output logic [VL_BITS/8-1:0] out_pred
);

  localparam int unsigned PW = VL_BITS / 8;

  esz_e             esz;
  logic [IMM_W-1:0] imm;
  logic             rsv;
  logic             hit;

  logic          vld_q, vld_d;
  logic          und_q, und_d;
  logic [PW-1:0] prd_q, prd_d;

  assign ridx_num = {3'b011, ridx_sel};

  pps_size_dec u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .enc   (enc_fld),
    .esz   (esz),
    .imm   (imm),
    .rsv   (rsv)
  );

  pps_elem_pick #(.PW(PW)) u_pick (
    .idx  (idx_val),
    .imm  (imm),
    .sh   (esz),
    .gate (src_gate),
    .hit  (hit)
  );

  // next state
  always_comb begin
    vld_d = in_valid;
    und_d = und_q;
    prd_d = prd_q;
    if (in_valid) begin
      und_d = rsv;
      prd_d = (!rsv && hit) ? src_keep : '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      und_q <= 1'b0;
      prd_q <= '0;
    end else begin
      vld_q <= vld_d;
      und_q <= und_d;
      prd_q <= prd_d;
    end
  end

  assign out_valid = vld_q;
  assign out_undef = und_q;
  assign out_pred  = prd_q;
  assign out_wr    = vld_q & ~und_q;

  a_r7_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_pred) && $stable(out_undef)));

  a_r6_rsv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_undef |-> (out_pred == '0 && !out_wr));

  a_r5_keep_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_pred == '0 || out_pred == $past(src_keep)));

endmodule

// File: tb/pred_pick_unit_tb_top.sv
module pred_pick_unit_tb_top;
  localparam int unsigned PW = 16;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [4:0]    enc_fld;
  logic [1:0]    ridx_sel;
  logic [31:0]   idx_val;
  logic [PW-1:0] src_keep;
  logic [PW-1:0] src_gate;
  logic [4:0]    ridx_num;
  logic          out_valid;
  logic          out_wr;
  logic          out_undef;
  logic [PW-1:0] out_pred;

  int n_vec = 0;
  int n_bad = 0;

  pred_pick_unit #(.VL_BITS(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_fld(enc_fld),
    .ridx_sel(ridx_sel), .idx_val(idx_val), .src_keep(src_keep),
    .src_gate(src_gate), .ridx_num(ridx_num), .out_valid(out_valid),
    .out_wr(out_wr), .out_undef(out_undef), .out_pred(out_pred)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent model of the result
  function automatic logic [PW-1:0] model(input logic [PW-1:0] keep, input logic [PW-1:0] gate,
                                          input logic [31:0] idx, input logic [4:0] enc);
    int sh;
    longint unsigned imm_v, cnt, el, pos;
    if (enc[0])                 begin sh = 0; imm_v = longint'(enc[4:1]); end
    else if (enc[1])            begin sh = 1; imm_v = longint'(enc[4:2]); end
    else if (enc[2])            begin sh = 2; imm_v = longint'(enc[4:3]); end
    else if (enc[3])            begin sh = 3; imm_v = longint'(enc[4]);   end
    else return '0;
    cnt = longint'(PW) >> sh;
    el  = (longint'(idx) + imm_v) % cnt;
    pos = el << sh;
    return gate[pos] ? keep : '0;
  endfunction

  task automatic apply(input logic [PW-1:0] keep, input logic [PW-1:0] gate,
                       input logic [31:0] idx, input logic [4:0] enc);
    @(negedge clk);
    src_keep = keep; src_gate = gate; idx_val = idx; enc_fld = enc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_cmp(input string req, input logic [PW-1:0] keep, input logic [PW-1:0] gate,
                         input logic [31:0] idx, input logic [4:0] enc);
    logic [PW-1:0] e;
    e = model(keep, gate, idx, enc);
    apply(keep, gate, idx, enc);
    chk(req, 32'(out_pred), 32'(e));
    chk({req, " valid"}, 32'(out_valid), 32'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; enc_fld = '0; ridx_sel = '0;
    idx_val = '0; src_keep = '0; src_gate = '0;
    repeat (3) @(negedge clk);
    chk("R9 out_valid", 32'(out_valid), 32'd0);
    chk("R9 out_wr", 32'(out_wr), 32'd0);
    chk("R9 out_undef", 32'(out_undef), 32'd0);
    chk("R9 out_pred", 32'(out_pred), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sizes;
    // R1 R2 R4: halfword, imm=4, idx=5 -> el 1 -> bit 2
    apply(16'hBEEF, 16'h0004, 32'd5, 5'b10010);
    chk("R4 halfword hit", 32'(out_pred), 32'h0000BEEF);
    chk("R10 write", 32'(out_wr), 32'd1);
    chk("R6 legal undef", 32'(out_undef), 32'd0);
    // same, gate bit between halfword positions has no effect
    apply(16'hBEEF, 16'h0002, 32'd5, 5'b10010);
    chk("R4 odd bit ignored", 32'(out_pred), 32'h0);
    // R1 R2: word, imm=3, idx=0 -> el 3 -> bit 12
    apply(16'h1234, 16'h1000, 32'd0, 5'b11100);
    chk("R2 word imm", 32'(out_pred), 32'h1234);
    // R1 R2: doubleword, imm=1, idx=0 -> el 1 -> bit 8
    apply(16'h5A5A, 16'h0100, 32'd0, 5'b11000);
    chk("R1 dword", 32'(out_pred), 32'h5A5A);
    // byte: imm=15, idx=0 -> bit 15
    apply(16'h00FF, 16'h8000, 32'd0, 5'b11111);
    chk("R2 byte imm", 32'(out_pred), 32'h00FF);
    for (int s = 0; s < 4; s++)
      for (int g = 0; g < 8; g++)
        run_cmp("R1 sweep", 16'hC3A5 ^ 16'(g * 97), 16'(1 << (g * 2 % 16)) | 16'(g * 4099),
                32'(g * 3), 5'((g << (s + 1)) | (1 << s)));
  endtask

  task automatic t_wrap;
    // R3: byte, imm=1, idx=0xFFFFFFFF -> (2^32) mod 16 = 0 -> bit 0
    apply(16'hA001, 16'h0001, 32'hFFFF_FFFF, 5'b00011);
    chk("R3 32-bit wrap", 32'(out_pred), 32'hA001);
    // R3: doubleword, imm=1, idx=7 -> 8 mod 2 = 0 -> bit 0
    apply(16'h7777, 16'h0001, 32'd7, 5'b11000);
    chk("R3 dword wrap", 32'(out_pred), 32'h7777);
    for (int k = 0; k < 16; k++)
      run_cmp("R3 wrap sweep", 16'(16'h0F0F + k), 16'h2481 << (k % 4),
              32'hFFFF_FFF0 + 32'(k), 5'((k << 1) | 1));
  endtask

  task automatic t_allfalse;
    for (int s = 0; s < 4; s++) begin
      apply(16'hFFFF, 16'h0000, 32'd9, 5'(1 << s));
      chk("R5 all-false gate", 32'(out_pred), 32'h0);
      chk("R10 write legal", 32'(out_wr), 32'd1);
    end
  endtask

  task automatic t_reserved;
    apply(16'hFFFF, 16'hFFFF, 32'd0, 5'b10000);
    chk("R6 undef", 32'(out_undef), 32'd1);
    chk("R6 zero", 32'(out_pred), 32'h0);
    chk("R6 no write", 32'(out_wr), 32'd0);
    apply(16'hFFFF, 16'hFFFF, 32'd1, 5'b00000);
    chk("R6 undef b", 32'(out_undef), 32'd1);
    apply(16'h3333, 16'hFFFF, 32'd1, 5'b00001);
    chk("R6 clears", 32'(out_undef), 32'd0);
    chk("R5 keep", 32'(out_pred), 32'h3333);
  endtask

  task automatic t_hold;
    apply(16'h9999, 16'hFFFF, 32'd2, 5'b00100);
    src_keep = 16'h1111; enc_fld = 5'b00000;
    repeat (3) @(negedge clk);
    chk("R7 valid drop", 32'(out_valid), 32'd0);
    chk("R7 hold pred", 32'(out_pred), 32'h9999);
    chk("R7 hold undef", 32'(out_undef), 32'd0);
    chk("R10 idle no write", 32'(out_wr), 32'd0);
  endtask

  task automatic t_regnum;
    for (int i = 0; i < 4; i++) begin
      ridx_sel = 2'(i);
      #1;
      chk("R8 regnum", 32'(ridx_num), 32'(12 + i));
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_regnum;
    t_sizes;
    t_wrap;
    t_allfalse;
    t_reserved;
    t_hold;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule